// File: doc/BRIEF.md
# Parallel sampling-converter host controller

This block sits in an FPGA and runs a 16-bit parallel-output sampling converter from the host side. It drives the converter's chip-select, read/convert and byte-select lines and watches the converter's BUSY line. It produces a convert strobe whose timing the converter accepts. It then waits for the end of conversion and reads the two's-complement result, either as one 16-bit word or as two bytes taken over the upper eight data lines. The result leaves on a valid/ready stream.

Every delay is a counter whose length is derived from a clock-frequency parameter and a time in nanoseconds. At start-up the controller resets the converter by strobing read/convert while BUSY is low, then leaves a full cycle time of acquisition before the first real conversion. If a conversion never completes, a watchdog raises an error pulse and runs the same reset again. A conversion is triggered by a one-cycle request, or continuously at the fastest legal rate in free-running mode.

Top module: `adcif_ctrl`

## Requirements
- R1: A convert strobe holds `adc_cs_n` and `adc_rc` both low for exactly ceil(CONV_NS·CLK_HZ/1e9) clock cycles (10 at defaults). CONV_NS is clamped to the legal 40 ns to 1750 ns window.
- R2: Two successive convert strobes (including the reset strobe) begin at least ceil(CYCLE_NS·CLK_HZ/1e9) cycles apart (400 at defaults).
- R3: Chip select is the strobing input. `adc_rc` is already low for at least ceil(SETUP_NS) cycles (1 at defaults) before the cycle in which both lines become low.
- R4: The data bus is enabled (`adc_cs_n`=0, `adc_rc`=1) only after a rising edge of BUSY, seen through a two-flop synchroniser. The first capture happens no earlier than ceil(EN_NS) cycles (9 at defaults) after the enable.
- R5: In word mode (`byte_mode`=0 when a conversion starts), `m_data` equals the full 16-bit bus value read while `adc_byte`=0.
- R6: In byte mode, the upper byte is read from `adc_bus[15:8]` with `adc_byte`=0. `adc_byte` is then raised, and after ceil(BYTE_NS) cycles (3 at defaults) the lower byte is read from `adc_bus[15:8]`. `m_data` is {first byte, second byte}.
- R7: While `rst` is high, `adc_cs_n`=1, `adc_rc`=1 and `m_valid`=0. After release, a reset strobe is issued at once. The first real conversion begins no sooner than PW+TC cycles after the reset strobe began.
- R8: If BUSY has not risen within ceil(TIMEOUT_NS) cycles (500 at defaults) after the convert strobe ends, `err_timeout` pulses for one cycle. The start-up reset strobe is then reissued, and no result is delivered for that conversion.
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_data` hold, and no convert strobe begins.
- R10: A one-cycle `start_req` pulse is remembered until it can be served. With `free_run`=1, conversions follow each other as fast as R2 and R9 allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request one conversion (pulse is held internally) |
| free_run | input | 1 | Convert continuously while high |
| byte_mode | input | 1 | 1: read as two bytes on the upper lines; 0: one 16-bit word |
| adc_busy | input | 1 | Converter BUSY, asynchronous, high when idle |
| adc_bus | input | 16 | Converter data lines |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Read (high) / convert (low) control |
| adc_byte | output | 1 | Byte select: 0 upper byte on upper lines, 1 swapped |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | 16 | Result, two's complement |
| err_timeout | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The hardest state to reach is the watchdog path. From the ports it needs a converter that drops BUSY and never raises it again, and then a reset strobe issued while BUSY is still low. The bench's converter responder has a stall switch for this. The responder models abort-on-strobe, so recovery can be followed to a correct result. Holding `m_ready` low under free-run is a second hard case: it shows that an unread result stops further conversions, not just further outputs.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

  typedef enum logic [3:0] {
    S_BOOT, S_RPRE, S_RLOW, S_RHOLD, S_IDLE,
    S_SETUP, S_CONV, S_WAIT, S_EN, S_BSW, S_REL
  } ctl_state_t;

  // Round a time in ns up to whole clock cycles, never below one.
  function automatic int unsigned ns2cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcif_sync.sv
module adcif_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/adcif_timer.sv
module adcif_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adcif_asm.sv
module adcif_asm #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_word,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [DATA_W-1:0] bus,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data
);
  localparam int BW = DATA_W / 2;

  logic [BW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (cap_hi) hi_q <= bus[DATA_W-1 -: BW];
      if (cap_word) begin
        m_data  <= bus;
        m_valid <= 1'b1;
      end else if (cap_lo) begin
        m_data  <= {hi_q, bus[DATA_W-1 -: BW]};
        m_valid <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adcif_ctrl.sv
module adcif_ctrl
  import adcif_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int          DATA_W     = 16,
  parameter int unsigned CONV_NS    = 100,
  parameter int unsigned CYCLE_NS   = 4000,
  parameter int unsigned SETUP_NS   = 10,
  parameter int unsigned EN_NS      = 83,
  parameter int unsigned DIS_NS     = 83,
  parameter int unsigned BYTE_NS    = 30,
  parameter int unsigned TIMEOUT_NS = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              free_run,
  input  logic              byte_mode,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_bus,
  output logic              adc_cs_n,
  output logic              adc_rc,
  output logic              adc_byte,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              err_timeout
);
  localparam int unsigned CONV_EFF = (CONV_NS < 40) ? 40 : ((CONV_NS > 1750) ? 1750 : CONV_NS);
  localparam int unsigned PW_C  = ns2cyc(CLK_HZ, CONV_EFF);
  localparam int unsigned TC_C  = ns2cyc(CLK_HZ, CYCLE_NS);
  localparam int unsigned SU_C  = ns2cyc(CLK_HZ, SETUP_NS);
  localparam int unsigned EN_C  = ns2cyc(CLK_HZ, EN_NS);
  localparam int unsigned DIS_C = ns2cyc(CLK_HZ, DIS_NS);
  localparam int unsigned BYT_C = ns2cyc(CLK_HZ, BYTE_NS);
  localparam int unsigned TO_C  = ns2cyc(CLK_HZ, TIMEOUT_NS);
  localparam int unsigned PH_MAX = max2(max2(max2(PW_C, TC_C), max2(TO_C, EN_C)),
                                        max2(max2(DIS_C, BYT_C), SU_C));
  localparam int PH_W  = $clog2(PH_MAX + 1);
  localparam int SPC_W = $clog2(TC_C + 1);

  ctl_state_t st, nxt;
  logic ph_load, ph_done, spc_load, spc_done, busy_rise;
  logic req_q, mode_q, go;
  logic cap_word, cap_hi, cap_lo;
  logic [PH_W-1:0] ph_val;
  int unsigned dur;

  adcif_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (adc_busy),
    .rise     (busy_rise)
  );

  // Phase timer: length of the current state, reused as the BUSY watchdog.
  adcif_timer #(.W(PH_W)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .load (ph_load),
    .val  (ph_val),
    .done (ph_done)
  );

  // Spacing timer: restarted at every convert strobe start.
  adcif_timer #(.W(SPC_W)) u_space (
    .clk  (clk),
    .rst  (rst),
    .load (spc_load),
    .val  (SPC_W'(TC_C - 1)),
    .done (spc_done)
  );

  always_comb go = (st == S_IDLE) && (req_q || free_run) && spc_done && !m_valid;

  always_comb begin
    nxt = st;
    unique case (st)
      S_BOOT:  nxt = S_RPRE;
      S_RPRE:  if (ph_done) nxt = S_RLOW;
      S_RLOW:  if (ph_done) nxt = S_RHOLD;
      S_RHOLD: if (ph_done) nxt = S_IDLE;
      S_IDLE:  if (go) nxt = S_SETUP;
      S_SETUP: if (ph_done) nxt = S_CONV;
      S_CONV:  if (ph_done) nxt = S_WAIT;
      S_WAIT:  if (busy_rise) nxt = S_EN;
               else if (ph_done) nxt = S_RPRE;
      S_EN:    if (ph_done) nxt = mode_q ? S_BSW : S_REL;
      S_BSW:   if (ph_done) nxt = S_REL;
      S_REL:   if (ph_done) nxt = S_IDLE;
      default: nxt = S_BOOT;
    endcase
  end

  always_comb begin
    unique case (nxt)
      S_RPRE, S_SETUP: dur = SU_C;
      S_RLOW, S_CONV:  dur = PW_C;
      S_RHOLD:         dur = TC_C;
      S_WAIT:          dur = TO_C;
      S_EN:            dur = EN_C;
      S_BSW:           dur = BYT_C;
      S_REL:           dur = DIS_C;
      default:         dur = 1;
    endcase
  end

  assign ph_load  = (nxt != st);
  assign ph_val   = PH_W'(dur - 1);
  assign spc_load = (nxt != st) && (nxt == S_CONV || nxt == S_RLOW);

  assign cap_word = (st == S_EN)  && ph_done && !mode_q;
  assign cap_hi   = (st == S_EN)  && ph_done &&  mode_q;
  assign cap_lo   = (st == S_BSW) && ph_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_BOOT;
      req_q       <= 1'b0;
      mode_q      <= 1'b0;
      adc_cs_n    <= 1'b1;
      adc_rc      <= 1'b1;
      adc_byte    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      st          <= nxt;
      req_q       <= (req_q && !go) || start_req;
      if (go) mode_q <= byte_mode;
      adc_cs_n    <= !(nxt inside {S_RLOW, S_CONV, S_EN, S_BSW});
      adc_rc      <= !(nxt inside {S_RPRE, S_RLOW, S_SETUP, S_CONV});
      adc_byte    <= (nxt == S_BSW);
      err_timeout <= (st == S_WAIT) && ph_done && !busy_rise;
    end
  end

  adcif_asm #(.DATA_W(DATA_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .cap_word (cap_word),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .bus      (adc_bus),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .m_data   (m_data)
  );
endmodule

// File: rtl/adcif_ctrl_chk.sv
module adcif_ctrl_chk
  import adcif_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int          DATA_W     = 16,
  parameter int unsigned CONV_NS    = 100,
  parameter int unsigned CYCLE_NS   = 4000,
  parameter int unsigned EN_NS      = 83,
  parameter int unsigned BYTE_NS    = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_cs_n,
  input logic              adc_rc,
  input logic              adc_byte,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              err_timeout,
  input logic              cap_word,
  input logic              cap_hi,
  input logic              cap_lo
);
  localparam int unsigned CONV_EFF = (CONV_NS < 40) ? 40 : ((CONV_NS > 1750) ? 1750 : CONV_NS);
  localparam int unsigned PW_C   = ns2cyc(CLK_HZ, CONV_EFF);
  localparam int unsigned TC_C   = ns2cyc(CLK_HZ, CYCLE_NS);
  localparam int unsigned EN_C   = ns2cyc(CLK_HZ, EN_NS);
  localparam int unsigned BYT_C  = ns2cyc(CLK_HZ, BYTE_NS);
  localparam int unsigned SAT    = 32'hFFFF_0000;

  logic conv_low, prev_low, conv_start, seen, prev_cs, prev_rc, prev_byte, chg;
  int unsigned lowcnt, gapcnt, stablecnt;

  assign conv_low   = !adc_cs_n && !adc_rc;
  assign conv_start = conv_low && !prev_low;
  assign chg        = (adc_cs_n != prev_cs) || (adc_rc != prev_rc) || (adc_byte != prev_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_low <= 1'b0; seen <= 1'b0;
      prev_cs <= 1'b1; prev_rc <= 1'b1; prev_byte <= 1'b0;
      lowcnt <= 0; gapcnt <= 0; stablecnt <= 0;
    end else begin
      prev_low  <= conv_low;
      prev_cs   <= adc_cs_n;
      prev_rc   <= adc_rc;
      prev_byte <= adc_byte;
      if (conv_start) seen <= 1'b1;
      if (conv_start) lowcnt <= 1;
      else if (conv_low && lowcnt < SAT) lowcnt <= lowcnt + 1;
      if (conv_start) gapcnt <= 1;
      else if (gapcnt < SAT) gapcnt <= gapcnt + 1;
      // Starts at 2 so that its value at the capture edge equals the
      // number of cycles the line levels have been applied.
      if (chg) stablecnt <= 2;
      else if (stablecnt < SAT) stablecnt <= stablecnt + 1;
    end
  end

  a_r1_pulse_width: assert property (@(posedge clk) disable iff (rst)
    (prev_low && !conv_low) |-> (lowcnt == PW_C));

  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    (conv_start && seen) |-> (gapcnt >= TC_C));

  a_r3_strobe_setup: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (!prev_rc && prev_cs));

  a_r4_read_window: assert property (@(posedge clk) disable iff (rst)
    (cap_word || cap_hi || cap_lo) |-> (!adc_cs_n && adc_rc));

  a_r4_enable_delay: assert property (@(posedge clk) disable iff (rst)
    (cap_word || cap_hi) |-> (stablecnt >= EN_C));

  a_r6_byte_order: assert property (@(posedge clk) disable iff (rst)
    (cap_hi |-> !adc_byte) and (cap_lo |-> (adc_byte && stablecnt >= BYT_C)));

  a_r8_timeout_reset: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> (adc_cs_n && !adc_rc && !m_valid));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r9_no_start: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !m_valid);
endmodule

bind adcif_ctrl adcif_ctrl_chk #(
  .CLK_HZ   (CLK_HZ),
  .DATA_W   (DATA_W),
  .CONV_NS  (CONV_NS),
  .CYCLE_NS (CYCLE_NS),
  .EN_NS    (EN_NS),
  .BYTE_NS  (BYTE_NS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .adc_cs_n    (adc_cs_n),
  .adc_rc      (adc_rc),
  .adc_byte    (adc_byte),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .err_timeout (err_timeout),
  .cap_word    (cap_word),
  .cap_hi      (cap_hi),
  .cap_lo      (cap_lo)
);

// File: tb/adcif_ctrl_test.sv
module adcif_ctrl_test;
  localparam int CLK_PERIOD = 10;      // 100 MHz, matches the default CLK_HZ
  localparam int PW_E   = 10;          // 100 ns strobe
  localparam int TC_E   = 400;         // 4000 ns cycle
  localparam int EN_E   = 9;           // 83 ns enable
  localparam int TO_E   = 500;         // 5000 ns watchdog
  localparam int CONV_CYC = 220;       // responder conversion time

  logic clk = 0, rst = 1;
  logic start_req = 0, free_run = 0, byte_mode = 0, m_ready = 0;
  logic adc_busy;
  logic [15:0] adc_bus;
  logic adc_cs_n, adc_rc, adc_byte, m_valid, err_timeout;
  logic [15:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcif_ctrl uut (
    .clk(clk), .rst(rst), .start_req(start_req), .free_run(free_run),
    .byte_mode(byte_mode), .adc_busy(adc_busy), .adc_bus(adc_bus),
    .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .adc_byte(adc_byte),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .err_timeout(err_timeout)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- converter responder ----------------
  function automatic logic [15:0] bus_view(logic [15:0] d, logic b);
    return b ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic logic [15:0] exp_result(logic [15:0] d, bit bm);
    logic [15:0] first, second;
    first  = bus_view(d, 1'b0);
    second = bus_view(d, 1'b1);
    return bm ? {first[15:8], second[15:8]} : d;
  endfunction

  function logic [15:0] next_sample(int idx);
    case (idx)
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'h0000;
      4: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  logic cv_busy = 1'b1;
  logic [15:0] cv_word = 16'h0;
  bit cv_active = 0, cv_abort = 0, cv_prev = 0, stall = 0;
  int cv_cnt = 0, cv_idx = 0;

  assign adc_busy = cv_busy;
  always_comb adc_bus = (!adc_cs_n && adc_rc) ?
                        (cv_busy ? bus_view(cv_word, adc_byte) : 16'hBAD0) : 16'hDEAD;

  always @(negedge clk) begin
    bit low;
    low = !adc_cs_n && !adc_rc;
    if (low && !cv_prev) begin
      if (cv_busy) begin
        cv_busy = 1'b0; cv_active = 1; cv_cnt = CONV_CYC;
      end else begin
        cv_active = 0; cv_abort = 1;
      end
    end
    if (cv_abort && !low) begin
      cv_abort = 0; cv_busy = 1'b1;
    end else if (cv_active && !stall) begin
      if (cv_cnt == 0) begin
        cv_word = next_sample(cv_idx); cv_idx++;
        cv_busy = 1'b1; cv_active = 0;
      end else cv_cnt--;
    end
    cv_prev = low;
  end

  // ---------------- port monitor ----------------
  bit cur_mode = 0;
  int cyc = 0, starts = 0, gap = 0, width = 0, win = 0, hs_cnt = 0, err_cnt = 0;
  int last_start_cyc = 0, err_delta = 0, boot_state = 1;
  bit seen = 0, win_bad = 0, p_low = 0, p_cs = 1, p_rc = 1;

  always @(negedge clk) begin
    bit low, rd;
    cyc++;
    if (rst) begin
      seen = 0; boot_state = 1; p_low = 0; p_cs = 1; p_rc = 1; win = 0;
    end else begin
      low = !adc_cs_n && !adc_rc;
      rd  = !adc_cs_n && adc_rc;
      if (low && !p_low) begin
        starts++;
        if (seen) chk(gap >= TC_E, "R2 strobe spacing", gap, TC_E);
        chk(!p_rc && p_cs, "R3 rc low before cs strobe", {p_cs, p_rc}, 2'b10);
        chk(!m_valid, "R9 no strobe while result pending", m_valid, 0);
        if (boot_state == 2) begin
          chk(gap >= PW_E + TC_E, "R7 acquisition after reset strobe", gap, PW_E + TC_E);
          boot_state = 0;
        end else if (boot_state == 1) boot_state = 2;
        seen = 1; gap = 1; width = 1; last_start_cyc = cyc;
      end else begin
        gap++;
        if (low) width++;
      end
      if (!low && p_low) chk(width == PW_E, "R1 strobe width", width, PW_E);
      if (rd) begin
        win++;
        if (!cv_busy) win_bad = 1;
      end else if (win > 0) begin
        chk(win >= EN_E && !win_bad, "R4 read window after BUSY", win, EN_E);
        win = 0; win_bad = 0;
      end
      if (m_valid && m_ready) begin
        hs_cnt++;
        chk(m_data == exp_result(cv_word, cur_mode), cur_mode ? "R6 byte result" : "R5 word result",
            m_data, exp_result(cv_word, cur_mode));
      end
      if (err_timeout) begin
        err_cnt++; err_delta = cyc - last_start_cyc; boot_state = 1;
      end
      p_low = low; p_cs = adc_cs_n; p_rc = adc_rc;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
  endtask

  task automatic wait_hs(int target, int limit, bit rnd, string tag);
    int k = 0;
    while (hs_cnt < target && k < limit) begin
      @(negedge clk);
      if (rnd) m_ready = 1'($urandom);
      k++;
    end
    m_ready = 1;
    chk(hs_cnt >= target, tag, hs_cnt, target);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int s, e, k;
    logic [15:0] snap;
    void'($urandom(32'h5eed_1234));
    wait_cyc(3);
    chk(adc_cs_n && adc_rc && !m_valid, "R7 reset levels", {adc_cs_n, adc_rc, m_valid}, 3'b110);
    wait_cyc(2);
    rst = 0;
    m_ready = 1;
    k = 0;
    while (starts < 1 && k < 10) begin @(negedge clk); k++; end
    chk(starts == 1, "R7 reset strobe issued at start-up", starts, 1);
    chk(!cv_busy || cv_active, "R7 reset strobe reached converter", cv_busy, 0);

    // R10: single pulse during the reset sequence is remembered
    pulse_req();
    wait_hs(1, 2000, 0, "R10 remembered request served");
    for (int i = 0; i < 3; i++) begin      // corner codes in word mode (R5)
      pulse_req();
      wait_hs(hs_cnt + 1, 2000, 0, "R5 word read completes");
    end

    // R6: byte mode under free-run (R10)
    wait_cyc(50);
    byte_mode = 1; cur_mode = 1; free_run = 1;
    wait_hs(hs_cnt + 6, 6000, 0, "R10 free-run byte results");
    free_run = 0;
    wait_cyc(600);

    // R9: back-pressure holds the result and stops conversions
    m_ready = 0; free_run = 1;
    k = 0;
    while (!m_valid && k < 2000) begin @(negedge clk); k++; end
    snap = m_data; s = starts;
    wait_cyc(1500);
    chk(m_valid, "R9 valid held", m_valid, 1);
    chk(m_data == snap, "R9 data held", m_data, snap);
    chk(starts == s, "R9 no conversion while pending", starts, s);
    m_ready = 1;
    wait_hs(hs_cnt + 1, 100, 0, "R9 released result accepted");
    free_run = 0;
    wait_cyc(600);

    // R5: word mode, random ready
    byte_mode = 0; cur_mode = 0; free_run = 1;
    wait_hs(hs_cnt + 10, 20000, 1, "R5 random-ready word results");
    free_run = 0;
    wait_cyc(600);

    // R8: stalled converter triggers watchdog and reset
    stall = 1; e = err_cnt; s = starts;
    pulse_req();
    k = 0;
    while (err_cnt == e && k < 3000) begin @(negedge clk); k++; end
    stall = 0;
    chk(err_cnt == e + 1, "R8 timeout flagged", err_cnt, e + 1);
    chk(err_delta >= PW_E + TO_E && err_delta <= PW_E + TO_E + 2, "R8 timeout delay",
        err_delta, PW_E + TO_E);
    wait_cyc(20);
    chk(starts == s + 2, "R8 reset strobe reissued", starts, s + 2);
    chk(!m_valid, "R8 no result from timed-out conversion", m_valid, 0);
    chk(cv_busy, "R8 converter left reset state", cv_busy, 1);
    pulse_req();
    wait_hs(hs_cnt + 1, 2000, 0, "R8 recovery conversion served");
    wait_cyc(20);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: all requirements incomplete actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule